// File: doc/BRIEF.md
# Programmable March Test Engine

This block is a microcoded self-test sequencer for a word-wide magnetic memory array. A short program is loaded through a write port into a small instruction store. When `start` is pulsed, the engine fetches one instruction at a time and expands it into a stream of single-word read and write commands on the memory port. Read data returns one cycle after a read command. The engine compares it against the expected solid pattern and records the outcome: a sticky fail flag, a saturating fail counter, and the address and data of the first miscompare.

There are two kinds of instruction. A march element lists up to four read/write operations, each with its own data polarity, and applies them at every address in ascending or descending order. A mirror bit makes one instruction stand for two elements: after the first pass, the element runs again with the address order reversed and every polarity inverted. The other instructions run non-march patterns around a moving base cell: galloping, walking and butterfly. Each instruction carries a read-current adjust value. The engine drives this value out with every read it issues. An end opcode stops fetching and raises `done`.

Top module: `mbist_engine`

## Requirements
- R1: While reset is held and directly after it, `done`, `fail` and `mem_en` are low and `fail_count` is zero.
- R2: The instruction word is 17 bits: opcode [16:14] (0 end, 1 march, 2 galloping, 3 walking, 4 butterfly, 5 to 7 treated as end), descending flag [13], mirror [12], read-current value [11:10], last operation index [9:8], and operation k in bits [2k+1:2k] as {write, polarity}. A march element issues operations 0 to last at one address before it moves to the next. It covers every address from 0 upward, or from the top address downward when the descending flag is set. Written data is all ones for polarity 1 and all zeros for polarity 0.
- R3: With the mirror bit set, a march element is followed at once by a second pass in the opposite address order, with every operation's polarity inverted.
- R4: Every read command drives `mem_radj` with the instruction's read-current value. Every write command drives `mem_radj` with zero.
- R5: Galloping, with background polarity p in bit 0, treats each base cell in ascending order. It writes ~p to the base. Then, for every other address in ascending order, it reads that address expecting p and then reads the base expecting ~p. Finally it writes p back to the base. This is 2N commands per base.
- R6: Walking writes ~p to the base, then reads every other address in ascending order expecting p, then reads the base expecting ~p, then writes p back to the base.
- R7: Butterfly splits the address into a row (upper half) and a column (lower half). After writing ~p to the base, it reads the neighbours at distance 1, 2, 4 and so on. For each distance the order is column+, column-, row+, row-, and neighbours that fall outside the array are skipped. It then reads the base expecting ~p and writes p back to it.
- R8: Read data is compared with the expected pattern in the cycle after the read command. Each miscompare increments `fail_count`, which saturates, and sets `fail`. `fail_addr` and `fail_data` hold the first miscompare until the next start.
- R9: An end or reserved opcode raises `done`, and no further commands are issued. A `start` pulse while idle or done restarts from instruction 0 and clears `fail`, `fail_count`, `fail_addr` and `fail_data`.
- R10: `prog_wr` writes `prog_data` into instruction slot `prog_addr` only while the engine is idle or done. Writes during a run are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts the program at slot 0 |
| prog_wr | input | 1 | Instruction store write strobe |
| prog_addr | input | $clog2(PROG_DEPTH) | Instruction slot |
| prog_data | input | 17 | Instruction word |
| mem_en | output | 1 | Memory command valid |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_radj | output | 2 | Read-current adjust for reads |
| mem_rdata | input | DATA_W | Read data, one cycle after the read |
| done | output | 1 | Program finished |
| fail | output | 1 | At least one miscompare |
| fail_count | output | CNT_W | Saturating miscompare count |
| fail_addr | output | ADDR_W | Address of first miscompare |
| fail_data | output | DATA_W | Data of first miscompare |

## Verification
Some properties are checked on every cycle. No command is issued once `done` is high, and `done` stays high until a start. Writes never carry a read-current value, and written data is always a solid pattern. The fail counter never decreases without a start. The first-fail record does not change once `fail` is set. Other behaviour can only be shown by the bench's scenarios, because it needs the whole command stream or a faulty memory. These scenarios cover the exact address and operation order of ascending, descending and mirrored elements, the neighbour order of galloping, walking and butterfly with edge skipping, the count and first address of failures under a stuck bit, and the ignoring of loads during a run.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
   localparam int OPC_W  = 3;
   localparam int RADJ_W = 2;

   typedef enum logic [OPC_W-1:0] {
      OPC_END    = 3'd0,
      OPC_MARCH  = 3'd1,
      OPC_GALLOP = 3'd2,
      OPC_WALK   = 3'd3,
      OPC_BFLY   = 3'd4
   } opc_e;

   // 17-bit word; ops[k] = {write, polarity}
   typedef struct packed {
      logic [OPC_W-1:0]  opc;
      logic              down;
      logic              mirror;
      logic [RADJ_W-1:0] radj;
      logic [1:0]        last_op;
      logic [3:0][1:0]   ops;
   } instr_t;

   localparam int INSTR_W = $bits(instr_t);

   typedef enum logic [1:0] {
      ST_BWR,
      ST_NRD,
      ST_BRD,
      ST_BRST
   } nm_step_e;
endpackage

// File: rtl/mbist_prog_mem.sv
module mbist_prog_mem #(
   parameter  int DEPTH = 16,
   parameter  int WIDTH = 17,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WIDTH-1:0] wr_data,
   input  logic [AW-1:0]    rd_addr,
   output logic [WIDTH-1:0] rd_data
);
   logic [WIDTH-1:0] slot_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) slot_q[wr_addr] <= wr_data;
   end

   assign rd_data = slot_q[rd_addr];
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 256,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              rd_issue,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_exp,
   input  logic [DATA_W-1:0] rdata,
   output logic              fail,
   output logic [CNT_W-1:0]  fail_count,
   output logic [ADDR_W-1:0] first_addr,
   output logic [DATA_W-1:0] first_data
);
   localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

   logic              vld_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] exp_q;
   logic              fail_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] faddr_q;
   logic [DATA_W-1:0] fdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q   <= 1'b0;
         addr_q  <= '0;
         exp_q   <= '0;
         fail_q  <= 1'b0;
         cnt_q   <= '0;
         faddr_q <= '0;
         fdata_q <= '0;
      end else begin
         vld_q <= rd_issue;
         if (rd_issue) begin
            addr_q <= rd_addr;
            exp_q  <= rd_exp;
         end
         if (clear) begin
            fail_q  <= 1'b0;
            cnt_q   <= '0;
            faddr_q <= '0;
            fdata_q <= '0;
         end else if (vld_q && (rdata != exp_q)) begin
            if (!fail_q) begin
               faddr_q <= addr_q;
               fdata_q <= rdata;
            end
            fail_q <= 1'b1;
            if (cnt_q != CNT_SAT) cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign fail       = fail_q;
   assign fail_count = cnt_q;
   assign first_addr = faddr_q;
   assign first_data = fdata_q;
endmodule

// File: rtl/mbist_seq.sv
module mbist_seq
   import mbist_pkg::*;
#(
   parameter int ADDR_W  = 18,
   parameter int PC_W    = 4,
   parameter bit BFLY_2D = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  instr_t            instr,
   output logic [PC_W-1:0]   pc,
   output logic              running,
   output logic              done,
   output logic              cmd_en,
   output logic              cmd_we,
   output logic              cmd_pol,
   output logic [ADDR_W-1:0] cmd_addr,
   output logic [RADJ_W-1:0] cmd_radj
);
   localparam logic [ADDR_W-1:0] A_MAX = {ADDR_W{1'b1}};
   localparam int COL_W  = BFLY_2D ? ADDR_W / 2 : ADDR_W;
   localparam int ROW_W  = ADDR_W - COL_W;
   localparam int N_DIST = (ROW_W > COL_W) ? ROW_W : COL_W;
   localparam int DIST_W = (N_DIST > 1) ? $clog2(N_DIST) : 1;
   localparam int SLOT_W = DIST_W + 2;
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(N_DIST * 4 - 1);

   typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RUN, S_DONE} state_e;

   state_e            state_q;
   logic [PC_W-1:0]   pc_q;
   instr_t            ir_q;
   logic              pass_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] nbr_q;
   logic [1:0]        opi_q;
   nm_step_e          step_q;
   logic [SLOT_W-1:0] slot_q;

   // butterfly neighbour candidate
   logic              cand_ok;
   logic [ADDR_W-1:0] cand_addr;
   logic [DIST_W-1:0] slot_dist;
   logic [1:0]        slot_dir;

   assign slot_dist = slot_q[SLOT_W-1:2];
   assign slot_dir  = slot_q[1:0];

   generate
      if (BFLY_2D) begin : g_grid
         always_comb begin
            int c, r, d;
            c = int'(addr_q[COL_W-1:0]);
            r = int'(addr_q[ADDR_W-1:COL_W]);
            d = 1 << slot_dist;
            case (slot_dir)
               2'd0:    c = c + d;
               2'd1:    c = c - d;
               2'd2:    r = r + d;
               default: r = r - d;
            endcase
            cand_ok   = (c >= 0) && (c < (1 << COL_W)) && (r >= 0) && (r < (1 << ROW_W));
            cand_addr = {r[ROW_W-1:0], c[COL_W-1:0]};
         end
      end else begin : g_line
         always_comb begin
            int a, d;
            a = int'(addr_q);
            d = 1 << slot_dist;
            a = slot_dir[0] ? a - d : a + d;
            cand_ok   = !slot_dir[1] && (a >= 0) && (a < (1 << ADDR_W));
            cand_addr = a[ADDR_W-1:0];
         end
      end
   endgenerate

   // gallop / walk neighbour stepping, skipping the base
   logic              nbr_last;
   logic [ADDR_W-1:0] nbr_inc, nbr_next, nbr_first;
   assign nbr_inc   = nbr_q + 1'b1;
   assign nbr_next  = (nbr_inc == addr_q) ? nbr_inc + 1'b1 : nbr_inc;
   assign nbr_last  = (nbr_q == A_MAX) || ((nbr_inc == A_MAX) && (addr_q == A_MAX));
   assign nbr_first = (addr_q == '0) ? ADDR_W'(1) : '0;

   logic       eff_down, at_end, known, bg;
   logic [1:0] cur_op;
   assign eff_down = ir_q.down ^ pass_q;
   assign at_end   = eff_down ? (addr_q == '0) : (addr_q == A_MAX);
   assign cur_op   = ir_q.ops[opi_q];
   assign bg       = ir_q.ops[0][0];
   assign known    = (instr.opc == OPC_MARCH) || (instr.opc == OPC_GALLOP) ||
                     (instr.opc == OPC_WALK)  || (instr.opc == OPC_BFLY);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         pc_q    <= '0;
         ir_q    <= '0;
         pass_q  <= 1'b0;
         addr_q  <= '0;
         nbr_q   <= '0;
         opi_q   <= '0;
         step_q  <= ST_BWR;
         slot_q  <= '0;
      end else begin
         case (state_q)
            S_IDLE, S_DONE: begin
               if (start) begin
                  state_q <= S_FETCH;
                  pc_q    <= '0;
               end
            end
            S_FETCH: begin
               ir_q    <= instr;
               pc_q    <= pc_q + 1'b1;
               pass_q  <= 1'b0;
               opi_q   <= '0;
               step_q  <= ST_BWR;
               slot_q  <= '0;
               addr_q  <= ((instr.opc == OPC_MARCH) && instr.down) ? A_MAX : '0;
               state_q <= known ? S_RUN : S_DONE;
            end
            S_RUN: begin
               if (ir_q.opc == OPC_MARCH) begin
                  if (opi_q != ir_q.last_op) begin
                     opi_q <= opi_q + 1'b1;
                  end else begin
                     opi_q <= '0;
                     if (!at_end) begin
                        addr_q <= eff_down ? addr_q - 1'b1 : addr_q + 1'b1;
                     end else if (ir_q.mirror && !pass_q) begin
                        pass_q <= 1'b1;
                        addr_q <= ir_q.down ? '0 : A_MAX;
                     end else begin
                        state_q <= S_FETCH;
                     end
                  end
               end else begin
                  case (step_q)
                     ST_BWR: begin
                        step_q <= ST_NRD;
                        nbr_q  <= nbr_first;
                        slot_q <= '0;
                     end
                     ST_NRD: begin
                        if (ir_q.opc == OPC_BFLY) begin
                           if (slot_q == SLOT_LAST) step_q <= ST_BRD;
                           else                     slot_q <= slot_q + 1'b1;
                        end else if (ir_q.opc == OPC_GALLOP) begin
                           step_q <= ST_BRD;
                        end else if (nbr_last) begin
                           step_q <= ST_BRD;
                        end else begin
                           nbr_q <= nbr_next;
                        end
                     end
                     ST_BRD: begin
                        if ((ir_q.opc == OPC_GALLOP) && !nbr_last) begin
                           step_q <= ST_NRD;
                           nbr_q  <= nbr_next;
                        end else begin
                           step_q <= ST_BRST;
                        end
                     end
                     default: begin
                        if (addr_q == A_MAX) begin
                           state_q <= S_FETCH;
                        end else begin
                           addr_q <= addr_q + 1'b1;
                           step_q <= ST_BWR;
                        end
                     end
                  endcase
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   always_comb begin
      cmd_en   = 1'b0;
      cmd_we   = 1'b0;
      cmd_pol  = 1'b0;
      cmd_addr = addr_q;
      if (state_q == S_RUN) begin
         if (ir_q.opc == OPC_MARCH) begin
            cmd_en  = 1'b1;
            cmd_we  = cur_op[1];
            cmd_pol = cur_op[0] ^ pass_q;
         end else begin
            case (step_q)
               ST_BWR: begin
                  cmd_en  = 1'b1;
                  cmd_we  = 1'b1;
                  cmd_pol = ~bg;
               end
               ST_NRD: begin
                  cmd_pol = bg;
                  if (ir_q.opc == OPC_BFLY) begin
                     cmd_en   = cand_ok;
                     cmd_addr = cand_addr;
                  end else begin
                     cmd_en   = 1'b1;
                     cmd_addr = nbr_q;
                  end
               end
               ST_BRD: begin
                  cmd_en  = 1'b1;
                  cmd_pol = ~bg;
               end
               default: begin
                  cmd_en  = 1'b1;
                  cmd_we  = 1'b1;
                  cmd_pol = bg;
               end
            endcase
         end
      end
   end

   assign cmd_radj = (cmd_en && !cmd_we) ? ir_q.radj : '0;
   assign pc       = pc_q;
   assign running  = (state_q == S_FETCH) || (state_q == S_RUN);
   assign done     = (state_q == S_DONE);
endmodule

// File: rtl/mbist_engine.sv
module mbist_engine
   import mbist_pkg::*;
#(
   parameter  int ADDR_W     = 18,
   parameter  int DATA_W     = 256,
   parameter  int PROG_DEPTH = 16,
   parameter  int CNT_W      = 16,
   parameter  bit BFLY_2D    = 1'b1,
   localparam int PC_W       = $clog2(PROG_DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               prog_wr,
   input  logic [PC_W-1:0]    prog_addr,
   input  logic [INSTR_W-1:0] prog_data,
   output logic               mem_en,
   output logic               mem_we,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic [RADJ_W-1:0]  mem_radj,
   input  logic [DATA_W-1:0]  mem_rdata,
   output logic               done,
   output logic               fail,
   output logic [CNT_W-1:0]   fail_count,
   output logic [ADDR_W-1:0]  fail_addr,
   output logic [DATA_W-1:0]  fail_data
);
   if (ADDR_W < 2 || ADDR_W > 30) begin : g_bad_addr_w
      $error("mbist_engine: ADDR_W must lie in 2..30");
   end
   if (PROG_DEPTH < 2 || (1 << PC_W) != PROG_DEPTH) begin : g_bad_depth
      $error("mbist_engine: PROG_DEPTH must be a power of two of at least 2");
   end
   if (DATA_W < 1 || CNT_W < 1) begin : g_bad_width
      $error("mbist_engine: DATA_W and CNT_W must be positive");
   end

   logic              running;
   logic [PC_W-1:0]   pc;
   logic [INSTR_W-1:0] instr_word;
   logic              cmd_pol;
   logic [DATA_W-1:0] pattern;

   mbist_prog_mem #(.DEPTH(PROG_DEPTH), .WIDTH(INSTR_W)) u_prog (
      .clk     (clk),
      .wr_en   (prog_wr & ~running),
      .wr_addr (prog_addr),
      .wr_data (prog_data),
      .rd_addr (pc),
      .rd_data (instr_word)
   );

   mbist_seq #(.ADDR_W(ADDR_W), .PC_W(PC_W), .BFLY_2D(BFLY_2D)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .instr    (instr_t'(instr_word)),
      .pc       (pc),
      .running  (running),
      .done     (done),
      .cmd_en   (mem_en),
      .cmd_we   (mem_we),
      .cmd_pol  (cmd_pol),
      .cmd_addr (mem_addr),
      .cmd_radj (mem_radj)
   );

   assign pattern   = {DATA_W{cmd_pol}};
   assign mem_wdata = pattern;

   mbist_cmp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_cmp (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear      (start & ~running),
      .rd_issue   (mem_en & ~mem_we),
      .rd_addr    (mem_addr),
      .rd_exp     (pattern),
      .rdata      (mem_rdata),
      .fail       (fail),
      .fail_count (fail_count),
      .first_addr (fail_addr),
      .first_data (fail_data)
   );
endmodule

// File: rtl/mbist_engine_chk.sv
module mbist_engine_chk #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 256,
   parameter int CNT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              mem_en,
   input logic              mem_we,
   input logic [DATA_W-1:0] mem_wdata,
   input logic [1:0]        mem_radj,
   input logic              done,
   input logic              fail,
   input logic [CNT_W-1:0]  fail_count,
   input logic [ADDR_W-1:0] fail_addr,
   input logic [DATA_W-1:0] fail_data
);
   p_quiet_when_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !mem_en);

   p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   p_radj_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> (mem_radj == 2'b00));

   p_solid_wdata_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_en && mem_we) |-> ((mem_wdata == '0) || (mem_wdata == '1)));

   p_count_grows_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !start |=> (fail_count >= $past(fail_count)));

   p_first_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !start) |=> ($stable(fail_addr) && $stable(fail_data)));

   p_flag_tracks_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fail_count != '0) |-> fail);
endmodule

bind mbist_engine mbist_engine_chk #(
   .ADDR_W (ADDR_W),
   .DATA_W (DATA_W),
   .CNT_W  (CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .mem_en     (mem_en),
   .mem_we     (mem_we),
   .mem_wdata  (mem_wdata),
   .mem_radj   (mem_radj),
   .done       (done),
   .fail       (fail),
   .fail_count (fail_count),
   .fail_addr  (fail_addr),
   .fail_data  (fail_data)
);

// File: tb/mbist_engine_tb_top.sv
module mbist_engine_tb_top;
   localparam int AW   = 4;
   localparam int DW   = 8;
   localparam int NW   = 1 << AW;
   localparam int LOGN = 2048;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic          prog_wr = 1'b0;
   logic [3:0]    prog_addr = '0;
   logic [16:0]   prog_data = '0;
   logic          mem_en, mem_we;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic [1:0]    mem_radj;
   logic          done, fail;
   logic [15:0]   fail_count;
   logic [AW-1:0] fail_addr;
   logic [DW-1:0] fail_data;

   always #5 clk = ~clk;

   mbist_engine #(.ADDR_W(AW), .DATA_W(DW), .PROG_DEPTH(16), .CNT_W(16), .BFLY_2D(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start),
      .prog_wr(prog_wr), .prog_addr(prog_addr), .prog_data(prog_data),
      .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_radj(mem_radj), .mem_rdata(mem_rdata),
      .done(done), .fail(fail), .fail_count(fail_count),
      .fail_addr(fail_addr), .fail_data(fail_data)
   );

   // memory model with optional stuck-at-1 bit
   logic [DW-1:0] store [NW];
   logic          flt_en = 1'b0;
   logic [AW-1:0] flt_addr = '0;
   logic [DW-1:0] flt_mask = '0;
   int            cmd_n = 0;
   logic [AW-1:0] log_addr [LOGN];
   logic          log_we   [LOGN];
   logic [DW-1:0] log_wd   [LOGN];
   logic [1:0]    log_radj [LOGN];

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) store[mem_addr] <= mem_wdata;
         else mem_rdata <= store[mem_addr] | ((flt_en && mem_addr == flt_addr) ? flt_mask : '0);
         if (cmd_n < LOGN) begin
            log_addr[cmd_n] <= mem_addr;
            log_we[cmd_n]   <= mem_we;
            log_wd[cmd_n]   <= mem_wdata;
            log_radj[cmd_n] <= mem_radj;
         end
         cmd_n <= cmd_n + 1;
      end
   end

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   task automatic chk(input string req, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic chk_cmd(input string req, input int idx, input int addr, input int we,
                          input int wd, input int radj);
      chk({req, " addr"}, longint'(log_addr[idx]), longint'(addr));
      chk({req, " we"},   longint'(log_we[idx]),   longint'(we));
      if (we == 1) chk({req, " wdata"}, longint'(log_wd[idx]), longint'(wd));
      else         chk({req, " radj"},  longint'(log_radj[idx]), longint'(radj));
   endtask

   function automatic logic [16:0] mk_march(input bit down, input bit mir, input logic [1:0] radj,
                                            input logic [1:0] last, input logic [7:0] ops);
      return {3'd1, down, mir, radj, last, ops};
   endfunction

   function automatic logic [16:0] mk_nm(input logic [2:0] opc, input logic [1:0] radj, input bit pol);
      return {opc, 2'b00, radj, 2'b00, 7'b0, pol};
   endfunction

   task automatic load(input int idx, input logic [16:0] w);
      @(negedge clk);
      prog_wr = 1'b1; prog_addr = 4'(idx); prog_data = w;
      @(negedge clk);
      prog_wr = 1'b0;
   endtask

   task automatic run_prog(output int ncmd);
      int base;
      base = cmd_n;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
      if (!done) chk("R9 done within limit", 0, 1);
      ncmd = cmd_n - base;
   endtask

   task automatic load_basic();
      load(0, mk_march(1'b0, 1'b0, 2'd0, 2'd0, 8'b0000_0010));   // up w0
      load(1, mk_march(1'b0, 1'b1, 2'd2, 2'd1, 8'b0000_1100));   // up (r0,w1), mirrored
      load(2, mk_march(1'b0, 1'b0, 2'd1, 2'd0, 8'b0000_0000));   // up r0
      load(3, 17'd0);
   endtask

   task automatic t_reset();
      chk("R1 done", longint'(done), 0);
      chk("R1 fail", longint'(fail), 0);
      chk("R1 mem_en", longint'(mem_en), 0);
      chk("R1 fail_count", longint'(fail_count), 0);
   endtask

   task automatic t_march_mirror();
      int n, b;
      load_basic();
      b = cmd_n;
      run_prog(n);
      chk("R2 march command total", n, 96);
      chk_cmd("R2 first write", b + 0, 0, 1, 8'h00, 0);
      chk_cmd("R2 last write", b + 15, 15, 1, 8'h00, 0);
      chk_cmd("R4 read radj", b + 16, 0, 0, 0, 2);
      chk_cmd("R2 op order", b + 17, 0, 1, 8'hFF, 0);
      chk_cmd("R3 mirror start", b + 48, 15, 0, 0, 2);
      chk_cmd("R3 mirror inverted", b + 49, 15, 1, 8'h00, 0);
      chk_cmd("R3 mirror descends", b + 50, 14, 0, 0, 2);
      chk_cmd("R4 radj next elem", b + 80, 0, 0, 0, 1);
      chk("R8 no fail healthy", longint'(fail_count), 0);
      chk("R9 done raised", longint'(done), 1);
   endtask

   task automatic t_march_down();
      int n, b;
      load(0, mk_march(1'b1, 1'b0, 2'd3, 2'd3, 8'b0010_0111));   // down (w1,r1,w0,r0)
      load(1, 17'd0);
      b = cmd_n;
      run_prog(n);
      chk("R2 four-op total", n, 64);
      chk_cmd("R2 down first", b + 0, 15, 1, 8'hFF, 0);
      chk_cmd("R2 down op1", b + 1, 15, 0, 0, 3);
      chk_cmd("R2 down op2", b + 2, 15, 1, 8'h00, 0);
      chk_cmd("R2 down next addr", b + 4, 14, 1, 8'hFF, 0);
      chk("R2 four-op no fail", longint'(fail), 0);
   endtask

   task automatic t_fault();
      int n;
      load_basic();
      flt_en = 1'b1; flt_addr = 4'd5; flt_mask = 8'h01;
      run_prog(n);
      chk("R8 fail count", longint'(fail_count), 2);
      chk("R8 first addr", longint'(fail_addr), 5);
      chk("R8 first data", longint'(fail_data), 8'h01);
      chk("R8 fail flag", longint'(fail), 1);
      flt_en = 1'b0;
   endtask

   task automatic t_restart();
      int n, c0;
      run_prog(n);
      chk("R9 restart clears count", longint'(fail_count), 0);
      chk("R9 restart clears flag", longint'(fail), 0);
      chk("R9 restart clears addr", longint'(fail_addr), 0);
      c0 = cmd_n;
      repeat (5) @(negedge clk);
      chk("R9 quiet after done", cmd_n - c0, 0);
   endtask

   task automatic t_load_ignored();
      int n;
      load_basic();
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      repeat (4) @(negedge clk);
      prog_wr = 1'b1; prog_addr = 4'd3; prog_data = mk_march(1'b0, 1'b0, 2'd0, 2'd0, 8'b0000_0011);
      @(negedge clk); prog_wr = 1'b0;
      for (int i = 0; i < 5000 && !done; i++) @(negedge clk);
      run_prog(n);
      chk("R10 load during run ignored", n, 96);
   endtask

   task automatic t_gallop();
      int n, b;
      load(0, mk_march(1'b0, 1'b0, 2'd0, 2'd0, 8'b0000_0010));
      load(1, mk_nm(3'd2, 2'd3, 1'b0));
      load(2, 17'd0);
      b = cmd_n;
      run_prog(n);
      chk("R5 gallop total", n, 16 + 2 * NW * NW);
      chk_cmd("R5 base write", b + 16, 0, 1, 8'hFF, 0);
      chk_cmd("R5 first nbr", b + 17, 1, 0, 0, 3);
      chk_cmd("R5 base reread", b + 18, 0, 0, 0, 3);
      chk_cmd("R5 second nbr", b + 19, 2, 0, 0, 3);
      chk_cmd("R5 base restore", b + 16 + 2 * NW - 1, 0, 1, 8'h00, 0);
      chk("R5 gallop no fail", longint'(fail), 0);
   endtask

   task automatic t_walk();
      int n, b;
      load(0, mk_march(1'b0, 1'b0, 2'd0, 2'd0, 8'b0000_0010));
      load(1, mk_nm(3'd3, 2'd1, 1'b0));
      load(2, 17'd0);
      b = cmd_n;
      run_prog(n);
      chk("R6 walk total", n, 16 + NW * (NW + 2));
      chk_cmd("R6 nbr a", b + 17, 1, 0, 0, 1);
      chk_cmd("R6 nbr b", b + 18, 2, 0, 0, 1);
      chk_cmd("R6 last nbr", b + 31, 15, 0, 0, 1);
      chk_cmd("R6 base read", b + 32, 0, 0, 0, 1);
      chk_cmd("R6 base restore", b + 33, 0, 1, 8'h00, 0);
      chk_cmd("R6 next base", b + 34, 1, 1, 8'hFF, 0);
      chk("R6 walk no fail", longint'(fail), 0);
   endtask

   task automatic t_bfly();
      int n, b, exp;
      load(0, mk_march(1'b0, 1'b0, 2'd0, 2'd0, 8'b0000_0010));
      load(1, mk_nm(3'd4, 2'd2, 1'b0));
      load(2, 17'd0);
      // 4x4 grid: per base count in-range neighbours at distances 1 and 2
      exp = 16;
      for (int a = 0; a < NW; a++) begin
         exp += 3;
         for (int d = 1; d <= 2; d = d * 2) begin
            if ((a % 4) + d < 4) exp++;
            if ((a % 4) - d >= 0) exp++;
            if ((a / 4) + d < 4) exp++;
            if ((a / 4) - d >= 0) exp++;
         end
      end
      b = cmd_n;
      run_prog(n);
      chk("R7 butterfly total", n, exp);
      chk_cmd("R7 base write", b + 16, 0, 1, 8'hFF, 0);
      chk_cmd("R7 col+1", b + 17, 1, 0, 0, 2);
      chk_cmd("R7 row+1", b + 18, 4, 0, 0, 2);
      chk_cmd("R7 col+2", b + 19, 2, 0, 0, 2);
      chk_cmd("R7 row+2", b + 20, 8, 0, 0, 2);
      chk_cmd("R7 base read", b + 21, 0, 0, 0, 2);
      chk_cmd("R7 base restore", b + 22, 0, 1, 8'h00, 0);
      chk("R7 butterfly no fail", longint'(fail), 0);
   endtask

   task automatic t_reserved();
      int n;
      load(0, {3'd7, 14'd0});
      run_prog(n);
      chk("R9 reserved opcode ends", n, 0);
      chk("R9 reserved done", longint'(done), 1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_march_mirror();
      t_march_down();
      t_fault();
      t_restart();
      t_load_ignored();
      t_gallop();
      t_walk();
      t_bfly();
      t_reserved();
      if (!finished) begin
         finished = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL R9 watchdog: actual running expected finished");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end
endmodule